// File: doc/BRIEF.md
# Decimal Bit Error Rate Calculator

This block turns a raw error tally and a measurement time in whole seconds into a bit error rate in normalised decimal form, d.dd × 10^-y. The rate is modelled for a tester that watches two of the sixteen bit lanes of a parallel word at a 10 Gb/s line rate. That model gives BER = 4·n / (5·t) × 10^-9, where n is the error count and t the time in seconds. The block needs no divider and no floating-point unit. The numerator is four times the count, built with a two-place left shift. The denominator is five times the time, built from a two-place shift plus one addition.

After a start strobe the block normalises the quotient. It multiplies whichever operand is too small by ten and moves the exponent one step each time. It then draws three decimal digits from the quotient. Each digit comes from repeated subtraction, followed by multiplication of the remainder by ten. A zero time is rejected with a flag, and a zero error count is reported with a separate flag. The result registers are loaded together with a one-cycle done pulse, and they keep their values until the next result is produced.

Top module: `ber_decimal_calc`

## Requirements
- R1: After reset, done, both flags, the three digits and the exponent are all zero.
- R2: A start with a time of zero sets bad_time, clears zero_result, and loads zero digits and a zero exponent. Done is raised in the cycle after start. This case takes priority over a zero error count.
- R3: A start with a nonzero time and a zero error count sets zero_result, clears bad_time, and loads zero digits and a zero exponent. Done is raised in the cycle after start.
- R4: For nonzero inputs, the digit outputs mant_int, mant_frac1 and mant_frac2, read as one three-digit number m, equal floor(4·n·10^(y-7) / (5·t)) without rounding. Each digit is a plain binary value from 0 to 9, and mant_int is from 1 to 9.
- R5: For nonzero inputs, exp_neg holds the y for which 100 ≤ m ≤ 999. With the default 24-bit operands, y lies between 2 and 17.
- R6: Done is high for exactly one clock per accepted start.
- R7: The digits, the exponent and both flags change only in a cycle where done is high. Between results they hold.
- R8: A start that arrives while a calculation is running is ignored. It produces no extra done and does not alter the result in progress.
- R9: A normal result clears both flags, even if the previous result set one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a calculation |
| err_count | input | CNT_W | Number of errors seen |
| seconds | input | CNT_W | Measurement time in seconds |
| done | output | 1 | One-cycle pulse when a result is loaded |
| zero_result | output | 1 | Error count was zero |
| bad_time | output | 1 | Time was zero; result invalid |
| mant_int | output | 4 | Leading mantissa digit (before the point) |
| mant_frac1 | output | 4 | First digit after the point |
| mant_frac2 | output | 4 | Second digit after the point |
| exp_neg | output | EXP_W | y in 10^-y |

## Verification
The assertions check the following on every clock:
- done never lasts two cycles;
- the two flags are never set together;
- the result registers hold whenever done is low;
- a zero time or a zero count leads to the matching flagged completion one cycle later;
- every normal result has a legal leading digit and legal fraction digits.

Only the bench scenarios can show that the digits and exponent have the right numeric values. The bench compares them with a model that works on wide integer arithmetic, at both ends of the 24-bit range and on random operands. It also shows that a start issued during a calculation leaves that result untouched.

// File: rtl/ber_calc_pkg.sv
package ber_calc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NORM  = 2'd1,
    ST_DIGIT = 2'd2
  } calc_state_t;

  localparam int NUM_DIGITS = 3;
  localparam int DIGIT_W    = 4;
  localparam int MAX_DIGIT  = 9;
endpackage

// File: rtl/ber_operand_scale.sv
module ber_operand_scale #(
  parameter int CNT_W = 24,
  parameter int W     = CNT_W + 10
) (
  input  logic [CNT_W-1:0] count_in,
  input  logic [CNT_W-1:0] time_in,
  output logic [W-1:0]     num_out,
  output logic [W-1:0]     den_out
);
  localparam int PAD_SH = W - CNT_W - 2;
  localparam int PAD_NO = W - CNT_W;

  // x4 on the count: two-place shift
  assign num_out = {{PAD_SH{1'b0}}, count_in, 2'b00};
  // x5 on the time: two-place shift plus one add
  assign den_out = {{PAD_SH{1'b0}}, time_in, 2'b00} + {{PAD_NO{1'b0}}, time_in};
endmodule

// File: rtl/ber_ten_mult.sv
module ber_ten_mult #(
  parameter int W = 34
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // x10 = x8 + x2
  assign dout = {din[W-4:0], 3'b000} + {din[W-2:0], 1'b0};
endmodule

// File: rtl/ber_decimal_calc.sv
module ber_decimal_calc
  import ber_calc_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int EXP_W     = 5,
  parameter int SCALE_EXP = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] err_count,
  input  logic [CNT_W-1:0] seconds,
  output logic             done,
  output logic             zero_result,
  output logic             bad_time,
  output logic [3:0]       mant_int,
  output logic [3:0]       mant_frac1,
  output logic [3:0]       mant_frac2,
  output logic [EXP_W-1:0] exp_neg
);
  localparam int W      = CNT_W + 10;
  localparam int ACC_W  = DIGIT_W * (NUM_DIGITS - 1);
  localparam int IDX_W  = $clog2(NUM_DIGITS);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(NUM_DIGITS - 1);
  localparam logic [EXP_W-1:0]   EXP_INIT = EXP_W'(SCALE_EXP);
  localparam logic [DIGIT_W-1:0] DIG_MAX  = DIGIT_W'(MAX_DIGIT);

  calc_state_t state;
  logic [W-1:0]       num_q, den_q;
  logic [W-1:0]       num_init, den_init, num_x10, den_x10;
  logic [EXP_W-1:0]   y_q;
  logic [DIGIT_W-1:0] q_cnt;
  logic [IDX_W-1:0]   idx_q;
  logic [ACC_W-1:0]   acc_q;
  logic               busy;

  assign busy = (state != ST_IDLE);

  ber_operand_scale #(.CNT_W(CNT_W), .W(W)) u_scale (
    .count_in (err_count),
    .time_in  (seconds),
    .num_out  (num_init),
    .den_out  (den_init)
  );

  ber_ten_mult #(.W(W)) u_num_x10 (.din(num_q), .dout(num_x10));
  ber_ten_mult #(.W(W)) u_den_x10 (.din(den_q), .dout(den_x10));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      num_q       <= '0;
      den_q       <= '0;
      y_q         <= '0;
      q_cnt       <= '0;
      idx_q       <= '0;
      acc_q       <= '0;
      done        <= 1'b0;
      zero_result <= 1'b0;
      bad_time    <= 1'b0;
      mant_int    <= '0;
      mant_frac1  <= '0;
      mant_frac2  <= '0;
      exp_neg     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (seconds == '0) begin
              bad_time    <= 1'b1;
              zero_result <= 1'b0;
              mant_int    <= '0;
              mant_frac1  <= '0;
              mant_frac2  <= '0;
              exp_neg     <= '0;
              done        <= 1'b1;
            end else if (err_count == '0) begin
              bad_time    <= 1'b0;
              zero_result <= 1'b1;
              mant_int    <= '0;
              mant_frac1  <= '0;
              mant_frac2  <= '0;
              exp_neg     <= '0;
              done        <= 1'b1;
            end else begin
              num_q <= num_init;
              den_q <= den_init;
              y_q   <= EXP_INIT;
              state <= ST_NORM;
            end
          end
        end
        ST_NORM: begin
          if (num_q < den_q) begin
            num_q <= num_x10;
            y_q   <= y_q + 1'b1;
          end else if (num_q >= den_x10) begin
            den_q <= den_x10;
            y_q   <= y_q - 1'b1;
          end else begin
            idx_q <= '0;
            q_cnt <= '0;
            state <= ST_DIGIT;
          end
        end
        ST_DIGIT: begin
          if ((num_q >= den_q) && (q_cnt < DIG_MAX)) begin
            num_q <= num_q - den_q;
            q_cnt <= q_cnt + 1'b1;
          end else begin
            acc_q <= {acc_q[ACC_W-DIGIT_W-1:0], q_cnt};
            num_q <= num_x10;
            q_cnt <= '0;
            if (idx_q == LAST_IDX) begin
              mant_int    <= acc_q[ACC_W-1 -: DIGIT_W];
              mant_frac1  <= acc_q[DIGIT_W-1:0];
              mant_frac2  <= q_cnt;
              exp_neg     <= y_q;
              zero_result <= 1'b0;
              bad_time    <= 1'b0;
              done        <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ber_decimal_calc_chk.sv
module ber_decimal_calc_chk #(
  parameter int CNT_W = 24,
  parameter int EXP_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] seconds,
  input logic             done,
  input logic             zero_result,
  input logic             bad_time,
  input logic [3:0]       mant_int,
  input logic [3:0]       mant_frac1,
  input logic [3:0]       mant_frac2,
  input logic [EXP_W-1:0] exp_neg
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(zero_result && bad_time));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({mant_int, mant_frac1, mant_frac2, exp_neg, zero_result, bad_time}));

  assert_bad_time_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && seconds == '0) |=> (done && bad_time && !zero_result));

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && seconds != '0 && err_count == '0) |=>
      (done && zero_result && mant_int == 4'd0 && exp_neg == '0));

  assert_digit_range_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !zero_result && !bad_time) |->
      (mant_int >= 4'd1 && mant_int <= 4'd9 && mant_frac1 <= 4'd9 && mant_frac2 <= 4'd9));

  assert_no_start_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> !(done && (zero_result || bad_time)));
endmodule

bind ber_decimal_calc ber_decimal_calc_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .err_count   (err_count),
  .seconds     (seconds),
  .done        (done),
  .zero_result (zero_result),
  .bad_time    (bad_time),
  .mant_int    (mant_int),
  .mant_frac1  (mant_frac1),
  .mant_frac2  (mant_frac2),
  .exp_neg     (exp_neg)
);

// File: tb/ber_decimal_calc_tb.sv
module ber_decimal_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;
  localparam int EXP_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] err_count = '0;
  logic [CNT_W-1:0] seconds = '0;
  logic done, zero_result, bad_time;
  logic [3:0] mant_int, mant_frac1, mant_frac2;
  logic [EXP_W-1:0] exp_neg;

  always #(CLK_PERIOD/2) clk = ~clk;

  ber_decimal_calc #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .err_count(err_count), .seconds(seconds),
    .done(done), .zero_result(zero_result), .bad_time(bad_time),
    .mant_int(mant_int), .mant_frac1(mant_frac1), .mant_frac2(mant_frac2),
    .exp_neg(exp_neg)
  );

  typedef struct {
    string tag;
    int    d0, d1, d2, y;
    bit    zf, bf;
  } exp_item_t;

  exp_item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  bit prev_done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic longint p10(input int k);
    longint r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  function automatic exp_item_t model(input longint n, input longint t, input string tag);
    exp_item_t it;
    longint nn, dd, m;
    it.tag = tag; it.d0 = 0; it.d1 = 0; it.d2 = 0; it.y = 0; it.zf = 0; it.bf = 0;
    if (t == 0) begin
      it.bf = 1;
    end else if (n == 0) begin
      it.zf = 1;
    end else begin
      nn = 4 * n;
      dd = 5 * t;
      for (int y = 1; y <= 20; y++) begin
        if (y >= 7) m = (nn * p10(y - 7)) / dd;
        else        m = nn / (dd * p10(7 - y));
        if (m >= 100 && m <= 999) begin
          it.y  = y;
          it.d0 = int'(m / 100);
          it.d1 = int'((m / 10) % 10);
          it.d2 = int'(m % 10);
          break;
        end
      end
    end
    return it;
  endfunction

  task automatic drive(input longint n, input longint t, input string tag);
    exp_q.push_back(model(n, t, tag));
    @(negedge clk);
    err_count = CNT_W'(n);
    seconds   = CNT_W'(t);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic wait_results(input int k);
    while (done_seen < k) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done)
        check(1'b0, "R6", "done width in cycles", 2, 1);
      if (done) begin
        done_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected done count", done_seen, done_seen - 1);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          check(bad_time == it.bf, it.tag, "bad_time", bad_time, it.bf);
          check(zero_result == it.zf, it.tag, "zero_result", zero_result, it.zf);
          check(mant_int == it.d0, it.tag, "mant_int", mant_int, it.d0);
          check(mant_frac1 == it.d1, it.tag, "mant_frac1", mant_frac1, it.d1);
          check(mant_frac2 == it.d2, it.tag, "mant_frac2", mant_frac2, it.d2);
          check(exp_neg == it.y, it.tag, "exp_neg", exp_neg, it.y);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: timeout got %0d expected %0d results", done_seen, exp_q.size());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n_res;
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 0, "R1", "done", done, 0);
    check({zero_result, bad_time} == 0, "R1", "flags", {zero_result, bad_time}, 0);
    check({mant_int, mant_frac1, mant_frac2} == 0, "R1", "digits",
          {mant_int, mant_frac1, mant_frac2}, 0);
    check(exp_neg == 0, "R1", "exp", exp_neg, 0);

    n_res = 0;
    drive(1, 1, "R4");              n_res++; wait_results(n_res);   // 8.00e-10
    drive(7, 0, "R2");              n_res++; wait_results(n_res);   // bad time
    drive(3, 7, "R9");              n_res++; wait_results(n_res);   // flags cleared, 3.42e-10
    drive(0, 5, "R3");              n_res++; wait_results(n_res);   // zero count
    drive(0, 0, "R2");              n_res++; wait_results(n_res);   // time priority
    drive(24'hFFFFFF, 1, "R5");     n_res++; wait_results(n_res);   // 1.34e-2, y=2
    drive(1, 24'hFFFFFF, "R5");     n_res++; wait_results(n_res);   // y=17
    drive(1000, 3600, "R4");        n_res++; wait_results(n_res);

    // R7: outputs hold between results
    snap = {mant_int, mant_frac1, mant_frac2, exp_neg[3:0]};
    repeat (25) @(negedge clk);
    check(snap == {mant_int, mant_frac1, mant_frac2, exp_neg[3:0]}, "R7", "held value",
          {mant_int, mant_frac1, mant_frac2, exp_neg[3:0]}, snap);

    // R8: start during a running calculation is ignored
    drive(1, 24'h00F000, "R8");
    @(negedge clk);
    err_count = 24'd0;
    seconds   = 24'd0;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    n_res++; wait_results(n_res);
    repeat (60) @(negedge clk);
    check(done_seen == n_res, "R8", "done count", done_seen, n_res);

    for (int i = 0; i < 12; i++) begin
      longint rn, rt;
      rn = longint'($urandom_range(16777215, 1) >> (i * 2 % 20));
      rt = longint'($urandom_range(16777215, 1) >> ((i * 5 + 3) % 22));
      if (rn == 0) rn = 1;
      if (rt == 0) rt = 1;
      drive(rn, rt, "R4");
      n_res++; wait_results(n_res);
    end

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6", "pending results", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule